// File: doc/BRIEF.md
# Parallel Printer Port Transmitter

This block is a byte-wide printer port seen by software as three registers: a data byte, a read-only view of the printer's status lines, and a control byte that drives the printer's control lines. A hardware send engine hands bytes to the printer, so software does not have to poll the port. Software first writes a byte and then pulses `send_i`. The engine then waits for the printer to report that it is ready. It keeps the byte steady on the data pins for one cycle and raises the strobe line for a fixed number of clocks. The other control lines are left untouched.

If the printer does not become ready before a time-out counter expires, the engine abandons the transfer without strobing. It then raises a sticky time-out flag. The printer-side status lines are plain synchronous inputs, and the data pins only ever drive toward the printer.

Top module: `lpt_tx`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x04 (only the active-low initialise line, bit 2, is inactive high), `pd_o` is 0, and strobe, `busy_o` and `timeout_o` are all 0.
- R2: Offset 0 is the data register. A read returns the last byte written, and `pd_o` always shows the register.
- R3: Offset 1 returns the status lines, combinationally: bit 7 = ready, bit 6 = `ack_ni`, bit 5 = `paper_out_i`, bit 4 = `selected_i`, bit 3 = `fault_ni`, bit 2 = `ack_alt_ni`, bits 1:0 = 0. Writes to offset 1 change no register.
- R4: Offset 2 is the control register, with strobe at bit 0, autofeed at bit 1, initialise (active low) at bit 2, select-input at bit 3, interrupt enable at bit 4 and direction at bit 5. Bits 5:1 are writable and drive `ctrl_o[5:1]`. Bit 0 is owned by the engine, so software writes to it are ignored. Bits 7:6 read 0, and offset 3 reads 0.
- R5: An accepted send does not strobe while `rdy_i` is low. Strobe rises two clocks after the clock edge that samples `rdy_i` high.
- R6: The strobe (`ctrl_o[0]`) stays high for exactly STROBE_CYC clocks. `pd_o` is unchanged during the cycle before strobe rises and for as long as strobe is high.
- R7: A strobe pulse leaves `ctrl_o[5:1]` unchanged.
- R8: The engine checks readiness at TIMEOUT_CYC+1 clock edges. If `rdy_i` is low at every one of them, the engine returns to idle without strobing, so `busy_o` is high for TIMEOUT_CYC+1 cycles, and it sets `timeout_o`. `timeout_o` stays set until the next accepted send clears it.
- R9: `busy_o` is high from the edge that accepts a send until the engine is idle again. With `rdy_i` high throughout, this lasts STROBE_CYC+2 cycles. A `send_i` seen while busy is ignored.
- R10: Writes to the data register while `busy_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| send_i | input | 1 | Send request, one clock |
| rdy_i | input | 1 | Printer can accept a byte |
| ack_ni | input | 1 | Acknowledge, active low |
| paper_out_i | input | 1 | Out of paper |
| selected_i | input | 1 | Printer selected |
| fault_ni | input | 1 | Error, active low |
| ack_alt_ni | input | 1 | Alternate acknowledge, active low |
| pd_o | output | 8 | Data pins to the printer |
| ctrl_o | output | 6 | Control lines, with strobe at bit 0 |
| busy_o | output | 1 | Send engine active |
| timeout_o | output | 1 | Sticky time-out flag |

## Verification
The bound checker watches every cycle for four things:
- strobe only ever rises two clocks after ready was sampled high;
- the data pins hold still before and during the strobe;
- the upper control lines move only after a register write, and strobe is never high while the engine is idle;
- the time-out flag rises only with strobe low and falls only when a send is accepted.

Only the bench's scenarios can show the rest: the exact strobe width and busy length, the time-out length, the register read-back values and the status bit mapping. They also show that repeat sends and data writes during a transfer are dropped, since that needs knowing which byte should have reached the printer.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;

  localparam logic [5:1] CTRL_RST = 5'b00010; // initialise line inactive

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_SETUP,
    S_STROBE
  } eng_state_e;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  input  logic       strb_i,
  input  logic [7:0] status_i,
  output logic [7:0] data_o,
  output logic [5:1] ctrl_o,
  output logic [7:0] rdata_o
);
  logic [7:0] data_q;
  logic [5:1] ctrl_q;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata_i[7:6], wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= CTRL_RST;
    end else if (wr_i) begin
      if (addr_i == OFF_DATA && !busy_i) data_q <= wdata_i;
      if (addr_i == OFF_CTRL)            ctrl_q <= wdata_i[5:1];
    end
  end

  always_comb begin
    case (addr_i)
      OFF_DATA: rdata_o = data_q;
      OFF_STAT: rdata_o = status_i;
      OFF_CTRL: rdata_o = {2'b00, ctrl_q, strb_i};
      default:  rdata_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/lpt_send_fsm.sv
module lpt_send_fsm
  import lpt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20,
  parameter int unsigned STROBE_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic rdy_i,
  output logic busy_o,
  output logic strb_o,
  output logic timeout_o
);
  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned STB_W = $clog2(STROBE_CYC + 1);

  eng_state_e       state_q;
  logic [TMO_W-1:0] tmo_q;
  logic [STB_W-1:0] stb_q;
  logic             strb_q, tflag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tmo_q   <= '0;
      stb_q   <= '0;
      strb_q  <= 1'b0;
      tflag_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (send_i) begin
          state_q <= S_WAIT;
          tmo_q   <= TMO_W'(TIMEOUT_CYC);
          tflag_q <= 1'b0;
        end
        S_WAIT: begin
          if (rdy_i) begin
            state_q <= S_SETUP;
          end else if (tmo_q == '0) begin
            state_q <= S_IDLE;
            tflag_q <= 1'b1;
          end else begin
            tmo_q <= tmo_q - 1'b1;
          end
        end
        S_SETUP: begin // data already stable for this cycle
          state_q <= S_STROBE;
          strb_q  <= 1'b1;
          stb_q   <= STB_W'(STROBE_CYC - 1);
        end
        S_STROBE: begin
          if (stb_q == '0) begin
            state_q <= S_IDLE;
            strb_q  <= 1'b0;
          end else begin
            stb_q <= stb_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign strb_o    = strb_q;
  assign timeout_o = tflag_q;
endmodule

// File: rtl/lpt_tx.sv
module lpt_tx #(
  parameter int unsigned TIMEOUT_CYC = 20,
  parameter int unsigned STROBE_CYC  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       send_i,
  input  logic       rdy_i,
  input  logic       ack_ni,
  input  logic       paper_out_i,
  input  logic       selected_i,
  input  logic       fault_ni,
  input  logic       ack_alt_ni,
  output logic [7:0] pd_o,
  output logic [5:0] ctrl_o,
  output logic       busy_o,
  output logic       timeout_o
);
  logic       busy, strb;
  logic [5:1] ctrl_hi;
  logic [7:0] status;

  assign status = {rdy_i, ack_ni, paper_out_i, selected_i, fault_ni, ack_alt_ni, 2'b00};

  lpt_send_fsm #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .STROBE_CYC (STROBE_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .send_i   (send_i),
    .rdy_i    (rdy_i),
    .busy_o   (busy),
    .strb_o   (strb),
    .timeout_o(timeout_o)
  );

  lpt_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .strb_i  (strb),
    .status_i(status),
    .data_o  (pd_o),
    .ctrl_o  (ctrl_hi),
    .rdata_o (rdata_o)
  );

  assign ctrl_o = {ctrl_hi, strb};
  assign busy_o = busy;
endmodule

// File: rtl/lpt_tx_chk.sv
module lpt_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       send_i,
  input logic       rdy_i,
  input logic [7:0] pd_o,
  input logic [5:0] ctrl_o,
  input logic       busy_o,
  input logic       timeout_o
);
  p_strobe_after_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[0]) |-> $past(rdy_i, 2));

  p_data_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |-> $stable(pd_o));

  p_ctrl_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i && addr_i == 2'd2) |-> $stable(ctrl_o[5:1]));

  p_strobe_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |-> busy_o);

  p_timeout_no_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !ctrl_o[0] && !busy_o);

  p_timeout_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> busy_o && $past(send_i));
endmodule

bind lpt_tx lpt_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .send_i   (send_i),
  .rdy_i    (rdy_i),
  .pd_o     (pd_o),
  .ctrl_o   (ctrl_o),
  .busy_o   (busy_o),
  .timeout_o(timeout_o)
);

// File: tb/lpt_tx_bench.sv
module lpt_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;
  localparam int STB = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, send = 1'b0, rdy = 1'b0;
  logic [7:0] wdata = '0, rdata, pd;
  logic       ack_n = 1'b1, pout = 1'b0, sel = 1'b1, fault_n = 1'b1, ack_alt_n = 1'b1;
  logic [5:0] ctrl;
  logic       busy, tmo;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic       prev_strb = 1'b0;
  int         width = 0;
  logic [5:1] ctrl_snap = '0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpt_tx #(.TIMEOUT_CYC(TMO), .STROBE_CYC(STB)) u_lpt_tx (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .send_i(send), .rdy_i(rdy), .ack_ni(ack_n),
    .paper_out_i(pout), .selected_i(sel), .fault_ni(fault_n), .ack_alt_ni(ack_alt_n),
    .pd_o(pd), .ctrl_o(ctrl), .busy_o(busy), .timeout_o(tmo)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // driver: push the byte the printer should receive, then request a send
  task automatic send_byte(input logic [7:0] b, input logic expect_it);
    if (expect_it) exp_q.push_back(b);
    @(negedge clk); send = 1'b1;
    @(negedge clk); send = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor: compare each strobe pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ctrl[0] && !prev_strb) begin
        width = 1;
        ctrl_snap = ctrl[5:1];
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected strobe", pd, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(pd == e, "R6 byte on pins at strobe", pd, e);
        end
      end else if (ctrl[0]) begin
        width++;
        if (ctrl[5:1] != ctrl_snap) chk(1'b0, "R7 control bits during strobe", ctrl, ctrl_snap);
      end else if (prev_strb) begin
        chk(width == STB, "R6 strobe width", width, STB);
      end
      prev_strb = ctrl[0];
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(2'd0, r); chk(r == 8'h00, "R1 data reset", r, 8'h00);
    reg_rd(2'd2, r); chk(r == 8'h04, "R1 ctrl reset", r, 8'h04);
    chk({busy, tmo, ctrl[0]} == 3'b000 && pd == 8'h00, "R1 outputs reset", {busy, tmo, ctrl[0], pd}, 0);

    // R2 data read-back and pins
    reg_wr(2'd0, 8'hA5); reg_rd(2'd0, r);
    chk(r == 8'hA5, "R2 data readback", r, 8'hA5);
    chk(pd == 8'hA5, "R2 data pins", pd, 8'hA5);

    // R3 status mapping, two patterns
    rdy = 1'b1; ack_n = 1'b0; pout = 1'b1; sel = 1'b0; fault_n = 1'b1; ack_alt_n = 1'b0;
    reg_rd(2'd1, r); chk(r == 8'b1010_1000, "R3 status pattern a", r, 8'b1010_1000);
    rdy = 1'b0; ack_n = 1'b1; pout = 1'b0; sel = 1'b1; fault_n = 1'b0; ack_alt_n = 1'b1;
    reg_rd(2'd1, r); chk(r == 8'b0101_0100, "R3 status pattern b", r, 8'b0101_0100);
    reg_wr(2'd1, 8'hFF);
    reg_rd(2'd0, r); chk(r == 8'hA5, "R3 status write leaves data", r, 8'hA5);
    reg_rd(2'd2, r); chk(r == 8'h04, "R3 status write leaves ctrl", r, 8'h04);

    // R4 control writes, bit 0 ignored, top bits zero, offset 3
    reg_wr(2'd2, 8'hFF); reg_rd(2'd2, r);
    chk(r == 8'h3E, "R4 ctrl readback", r, 8'h3E);
    chk(ctrl == 6'h3E, "R4 ctrl pins", ctrl, 6'h3E);
    reg_wr(2'd2, 8'h0B); reg_rd(2'd2, r);
    chk(r == 8'h0A, "R4 ctrl strobe bit ignored", r, 8'h0A);
    reg_rd(2'd3, r); chk(r == 8'h00, "R4 offset 3", r, 8'h00);

    // R9 busy length with ready high, R7 via monitor
    rdy = 1'b1;
    reg_wr(2'd0, 8'h3C);
    send_byte(8'h3C, 1'b1);
    cnt = 1;
    while (busy) begin @(negedge clk); if (busy) cnt++; end
    chk(cnt == STB + 2, "R9 busy cycles", cnt, STB + 2);
    chk(ctrl[5:1] == 5'b00101, "R7 ctrl kept after send", ctrl[5:1], 5'b00101);

    // R5 wait for ready
    rdy = 1'b0;
    reg_wr(2'd0, 8'h5A);
    send_byte(8'h5A, 1'b1);
    repeat (6) @(negedge clk);
    chk(busy && !ctrl[0], "R5 waiting, no strobe", {busy, ctrl[0]}, 2'b10);
    chk(exp_q.size() == 1, "R5 byte not yet sent", exp_q.size(), 1);
    rdy = 1'b1;
    wait_idle();
    chk(exp_q.size() == 0, "R5 byte sent after ready", exp_q.size(), 0);

    // R9 repeat send and R10 data write while busy are ignored
    reg_wr(2'd0, 8'hC3);
    rdy = 1'b0;
    send_byte(8'hC3, 1'b1);
    reg_wr(2'd0, 8'h11);
    send_byte(8'h11, 1'b0);
    reg_rd(2'd0, r); chk(r == 8'hC3, "R10 data write while busy", r, 8'hC3);
    rdy = 1'b1;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R9 repeat send ignored", {busy, 8'(exp_q.size())}, 0);
    reg_rd(2'd0, r); chk(r == 8'hC3, "R10 data after transfer", r, 8'hC3);

    // R8 time-out
    rdy = 1'b0;
    send_byte(8'h00, 1'b0);
    cnt = 1;
    while (busy) begin @(negedge clk); if (busy) cnt++; end
    chk(cnt == TMO + 1, "R8 time-out length", cnt, TMO + 1);
    chk(tmo == 1'b1, "R8 time-out flag set", tmo, 1);
    repeat (5) @(negedge clk);
    chk(tmo == 1'b1, "R8 time-out flag sticky", tmo, 1);
    rdy = 1'b1;
    reg_wr(2'd0, 8'h7E);
    send_byte(8'h7E, 1'b1);
    chk(tmo == 1'b0, "R8 time-out cleared by send", tmo, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule